// File: doc/BRIEF.md
# Multiprocessor Wake-Up UART Receiver

This block receives asynchronous serial frames on a single line and places the received bytes in a small receive queue. When multiprocessor mode is on, each frame carries one extra bit after the data byte. That bit tags the frame as an address (ID) frame when it is 1, or as a data frame when it is 0. The block samples the line on a 16x oversampling tick. The tick comes either from an internal rate source or from an external clock input, selected by a two-bit clock-source field. The same field also decides whether the serial clock pin is driven.

Software can arm a wake-up filter. While the filter is armed, data frames are thrown away. They do not enter the queue, no error checking is done on them, and no status flag or interrupt is raised for them. The first ID frame that arrives disarms the filter in hardware. That ID frame is queued and checked like any normal frame, and the multiprocessor-bit flag is set. Normal reception then continues. The filter has effect only in asynchronous mode, with infrared mode off and multiprocessor mode on. In any other configuration the stored arm bit is kept but has no effect.

Top module: `mpu_rx_filter`

## Requirements
- R1: A frame has these parts, in order: a low start bit, then DATA_W data bits sent LSB first, then the multiprocessor bit (present only when `cfg_mp_en_i` is 1), then a high stop bit. Each bit lasts 16 ticks and is sampled at its middle. A frame that is accepted is pushed into the queue and sets flag bit 0 (data-ready).
- R2: The queue holds 16 entries and is read with `rd_valid_o`/`rd_ready_i`, oldest entry first. If an accepted frame completes while the queue is full, that frame is dropped and flag bit 2 (overrun) is set.
- R3: An accepted frame whose stop bit is sampled low sets flag bit 1 (framing error). The frame is still queued.
- R4: The filter is active only when the arm bit is 1, `cfg_async_i` is 1, `cfg_irda_i` is 0 and `cfg_mp_en_i` is 1. In every other case, frames are received normally whatever the value of the arm bit.
- R5: While the filter is active, a frame whose multiprocessor bit is 0 is discarded. It causes no queue write and sets none of the flags, whatever its stop bit, so neither interrupt is raised.
- R6: While the filter is active, a frame whose multiprocessor bit is 1 clears the arm bit and sets flag bit 3 (multiprocessor bit seen). That frame is queued and framing-checked like a normal frame.
- R7: The arm bit is 0 after reset. A pulse on `wake_wr_i` loads `wake_wdata_i` into it. If that write falls in the same cycle as the hardware clear, the hardware clear wins.
- R8: `irq_rx_o` is high when `cfg_rie_i` is 1 and flag bit 0 is set. `irq_err_o` is high when `cfg_rie_i` is 1 and flag bit 1 or flag bit 2 is set.
- R9: All flags are sticky. Bit n is cleared by a one-cycle pulse on `flag_clr_i[n]`. If a set and a clear fall in the same cycle, the set wins. An accepted frame with its multiprocessor bit at 1 sets bit 3 when multiprocessor mode is on.
- R10: When `cfg_cke_i[1]` is 0, the receiver uses `tick_int_i` as its tick. When `cfg_cke_i[1]` is 1, it uses `tick_ext_i`, and `cfg_cke_i[0]` is ignored.
- R11: `sck_oe_o` is 1 only when `cfg_async_i` is 1, `cfg_cke_i[1]` is 0 and `cfg_cke_i[0]` is 1.
- R12: If the line is high again at the middle of the start bit, the receiver goes back to idle and produces no frame. After a stop bit sampled low, the receiver waits for the line to return high before it accepts a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_int_i | input | 1 | Internal 16x oversampling tick |
| tick_ext_i | input | 1 | External 16x oversampling tick |
| cfg_async_i | input | 1 | 1 = asynchronous mode |
| cfg_irda_i | input | 1 | 1 = infrared mode selected |
| cfg_mp_en_i | input | 1 | 1 = frames carry a multiprocessor bit |
| cfg_cke_i | input | 2 | Clock source select and clock pin output enable |
| cfg_rie_i | input | 1 | Receive and receive-error interrupt enable |
| wake_wr_i | input | 1 | Write strobe for the filter arm bit |
| wake_wdata_i | input | 1 | Value written to the filter arm bit |
| flag_clr_i | input | 4 | Per-flag clear pulses (bit 0 data-ready, bit 1 framing, bit 2 overrun, bit 3 multiprocessor bit) |
| wake_en_o | output | 1 | Current filter arm bit |
| flags_o | output | 4 | Sticky status flags, same bit order as flag_clr_i |
| rd_valid_o | output | 1 | Queue holds at least one byte |
| rd_ready_i | input | 1 | Consumer takes the head byte |
| rd_data_o | output | DATA_W | Head byte of the queue |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_err_o | output | 1 | Receive-error interrupt |
| sck_oe_o | output | 1 | Drive enable for the serial clock pin |

## Verification
The armed state is the one state that cannot be seen directly at the ports, so mistakes in it must be caught through their effects. If the filter is wrongly seen as inactive, the next data frame shows up on `rd_valid_o` and `flags_o[0]` a few cycles after its stop-bit mid-sample. If the filter is wrongly seen as active, the frame is missing at that same point. If the arm bit is not cleared by hardware, `wake_en_o` stays high after the ID frame, and the following data frame is lost. A bit-counter or sampling-phase error shows up one frame later as a wrong `rd_data_o` value or as a false framing flag.

// File: rtl/mpu_rx_pkg.sv
package mpu_rx_pkg;
   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   localparam int FLAG_RDY  = 0;
   localparam int FLAG_FER  = 1;
   localparam int FLAG_OVR  = 2;
   localparam int FLAG_MPB  = 3;
   localparam int NUM_FLAGS = 4;

   typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/mpu_rx_sampler.sv
module mpu_rx_sampler
   import mpu_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_i,
   input  logic              mp_en,
   output logic              frame_vld,
   output logic [DATA_W-1:0] frame_data,
   output logic              frame_mpb,
   output logic              frame_stop_ok
);
   localparam int CNT_W = $clog2(OSR);
   localparam int MID   = OSR / 2 - 1;
   localparam int BIT_W = $clog2(DATA_W + 2);

   generate
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("mpu_rx_sampler: OSR must be even and at least 4");
      end
      if (DATA_W < 5) begin : g_bad_w
         $error("mpu_rx_sampler: DATA_W must be at least 5");
      end
   endgenerate

   logic rx_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx_s = rx_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= (sh << 1) | SYNC_STAGES'(rx_i);
         end
         assign rx_s = sh[SYNC_STAGES-1];
      end
   endgenerate

   rx_state_e          st;
   logic [CNT_W-1:0]   cnt;
   logic [BIT_W-1:0]   bit_idx;
   logic [BIT_W-1:0]   last_idx;
   logic               armed;

   assign last_idx = mp_en ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st            <= RX_IDLE;
         cnt           <= '0;
         bit_idx       <= '0;
         armed         <= 1'b0;
         frame_vld     <= 1'b0;
         frame_data    <= '0;
         frame_mpb     <= 1'b0;
         frame_stop_ok <= 1'b0;
      end else begin
         frame_vld <= 1'b0;
         if (tick) begin
            unique case (st)
               RX_IDLE: begin
                  if (rx_s) begin
                     armed <= 1'b1;
                  end else if (armed) begin
                     st  <= RX_START;
                     cnt <= '0;
                  end
               end
               RX_START: begin
                  if (cnt == CNT_W'(MID)) begin
                     cnt <= '0;
                     if (rx_s) begin
                        st <= RX_IDLE;
                     end else begin
                        st        <= RX_BITS;
                        bit_idx   <= '0;
                        frame_mpb <= 1'b0;
                     end
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (cnt == CNT_W'(OSR - 1)) begin
                     cnt <= '0;
                     if (bit_idx < BIT_W'(DATA_W)) frame_data <= {rx_s, frame_data[DATA_W-1:1]};
                     else                          frame_mpb  <= rx_s;
                     if (bit_idx == last_idx) st <= RX_STOP;
                     bit_idx <= bit_idx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (cnt == CNT_W'(OSR - 1)) begin
                     cnt           <= '0;
                     frame_vld     <= 1'b1;
                     frame_stop_ok <= rx_s;
                     armed         <= 1'b0;
                     st            <= RX_IDLE;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mpu_rx_fifo.sv
module mpu_rx_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   output logic             full,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [WIDTH-1:0] dout
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("mpu_rx_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp, wp_nx, rp_nx;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign full      = (cnt == CW'(DEPTH));
   assign out_valid = (cnt != '0);
   assign dout      = mem[rp];
   assign do_push   = push && !full;
   assign do_pop    = out_valid && out_ready;

   generate
      if (POW2) begin : g_wrap_free
         assign wp_nx = wp + 1'b1;
         assign rp_nx = rp + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_nx = (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_nx;
         if (do_pop)  rp <= rp_nx;
         unique case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/mpu_rx_wake_ctl.sv
module mpu_rx_wake_ctl
   import mpu_rx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_vld,
   input  logic      frame_mpb,
   input  logic      frame_stop_ok,
   input  logic      fifo_full,
   input  logic      cfg_async,
   input  logic      cfg_irda,
   input  logic      cfg_mp_en,
   input  logic      sw_wr,
   input  logic      sw_wdata,
   input  flag_vec_t flag_clr,
   output logic      filt_en,
   output logic      wake_active,
   output logic      fifo_push,
   output flag_vec_t flags
);
   logic      qualify, accept, overrun, hw_clear;
   flag_vec_t set_vec;

   assign qualify     = cfg_async && !cfg_irda && cfg_mp_en;
   assign wake_active = filt_en && qualify;
   assign accept      = frame_vld && (!wake_active || frame_mpb);
   assign fifo_push   = accept && !fifo_full;
   assign overrun     = accept && fifo_full;
   assign hw_clear    = frame_vld && wake_active && frame_mpb;

   always_comb begin
      set_vec           = '0;
      set_vec[FLAG_RDY] = fifo_push;
      set_vec[FLAG_FER] = accept && !frame_stop_ok;
      set_vec[FLAG_OVR] = overrun;
      set_vec[FLAG_MPB] = accept && cfg_mp_en && frame_mpb;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_en <= 1'b0;
         flags   <= '0;
      end else begin
         if (hw_clear)   filt_en <= 1'b0;
         else if (sw_wr) filt_en <= sw_wdata;
         flags <= (flags & ~flag_clr) | set_vec;
      end
   end
endmodule

// File: rtl/mpu_rx_filter.sv
module mpu_rx_filter
   import mpu_rx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int FIFO_DEPTH  = 16,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic              tick_int_i,
   input  logic              tick_ext_i,
   input  logic              cfg_async_i,
   input  logic              cfg_irda_i,
   input  logic              cfg_mp_en_i,
   input  logic [1:0]        cfg_cke_i,
   input  logic              cfg_rie_i,
   input  logic              wake_wr_i,
   input  logic              wake_wdata_i,
   input  logic [3:0]        flag_clr_i,
   output logic              wake_en_o,
   output logic [3:0]        flags_o,
   output logic              rd_valid_o,
   input  logic              rd_ready_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              irq_rx_o,
   output logic              irq_err_o,
   output logic              sck_oe_o
);
   generate
      if (NUM_FLAGS != 4) begin : g_bad_flags
         $error("mpu_rx_filter: flag port width assumes four flags");
      end
   endgenerate

   logic              tick_sel;
   logic              frame_vld, frame_mpb, frame_stop_ok;
   logic [DATA_W-1:0] frame_data;
   logic              fifo_full, fifo_push, wake_active, filt_en;
   flag_vec_t         flags;

   assign tick_sel = cfg_cke_i[1] ? tick_ext_i : tick_int_i;
   assign sck_oe_o = cfg_async_i && !cfg_cke_i[1] && cfg_cke_i[0];

   mpu_rx_sampler #(
      .DATA_W(DATA_W), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)
   ) u_sampler (
      .clk(clk), .rst_n(rst_n), .tick(tick_sel), .rx_i(rx_i), .mp_en(cfg_mp_en_i),
      .frame_vld(frame_vld), .frame_data(frame_data), .frame_mpb(frame_mpb),
      .frame_stop_ok(frame_stop_ok)
   );

   mpu_rx_wake_ctl u_wake (
      .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_mpb(frame_mpb),
      .frame_stop_ok(frame_stop_ok), .fifo_full(fifo_full),
      .cfg_async(cfg_async_i), .cfg_irda(cfg_irda_i), .cfg_mp_en(cfg_mp_en_i),
      .sw_wr(wake_wr_i), .sw_wdata(wake_wdata_i), .flag_clr(flag_vec_t'(flag_clr_i)),
      .filt_en(filt_en), .wake_active(wake_active), .fifo_push(fifo_push), .flags(flags)
   );

   mpu_rx_fifo #(
      .WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(fifo_push), .din(frame_data), .full(fifo_full),
      .out_valid(rd_valid_o), .out_ready(rd_ready_i), .dout(rd_data_o)
   );

   assign wake_en_o = filt_en;
   assign flags_o   = flags;
   assign irq_rx_o  = cfg_rie_i && flags[FLAG_RDY];
   assign irq_err_o = cfg_rie_i && (flags[FLAG_FER] || flags[FLAG_OVR]);
endmodule

// File: rtl/mpu_rx_filter_chk.sv
module mpu_rx_filter_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_vld,
   input logic       frame_mpb,
   input logic       wake_active,
   input logic       fifo_push,
   input logic       fifo_full,
   input logic       filt_en,
   input logic [3:0] flags,
   input logic [3:0] flag_clr
);
   // R5: a suppressed data frame never reaches the queue
   p_no_push_suppressed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_active && frame_vld && !frame_mpb) |-> !fifo_push);

   // R5: a suppressed data frame leaves every flag untouched
   p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_active && frame_vld && !frame_mpb && flag_clr == 4'b0) |=> $stable(flags));

   // R6: an ID frame seen while filtering disarms the filter
   p_auto_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_active && frame_vld && frame_mpb) |=> !filt_en);

   // R2: an accepted frame at a full queue raises overrun
   p_overrun_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && fifo_full && (!wake_active || frame_mpb)) |=> flags[2]);

   // R1: every queue write raises data-ready
   p_ready_after_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |=> flags[0]);
endmodule

bind mpu_rx_filter mpu_rx_filter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_mpb(frame_mpb),
   .wake_active(wake_active), .fifo_push(fifo_push), .fifo_full(fifo_full),
   .filt_en(filt_en), .flags(flags), .flag_clr(flag_clr_i)
);

// File: tb/mpu_rx_filter_bench.sv
`timescale 1ns/1ps
module mpu_rx_filter_bench;
   localparam int BITCLK = 32; // 16 ticks, one tick every 2 clocks

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1;
   logic tick_int, tick_ext;
   logic int_run = 1'b1, ext_run = 1'b0;
   logic cfg_async = 1'b1, cfg_irda = 1'b0, cfg_mp_en = 1'b0, cfg_rie = 1'b1;
   logic [1:0] cfg_cke = 2'b00;
   logic wake_wr = 1'b0, wake_wdata = 1'b0;
   logic [3:0] flag_clr = 4'b0;
   logic rd_ready = 1'b0;
   logic wake_en, rd_valid, irq_rx, irq_err, sck_oe;
   logic [3:0] flags;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   mpu_rx_filter u_mpu_rx_filter (
      .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_int_i(tick_int), .tick_ext_i(tick_ext),
      .cfg_async_i(cfg_async), .cfg_irda_i(cfg_irda), .cfg_mp_en_i(cfg_mp_en),
      .cfg_cke_i(cfg_cke), .cfg_rie_i(cfg_rie), .wake_wr_i(wake_wr),
      .wake_wdata_i(wake_wdata), .flag_clr_i(flag_clr), .wake_en_o(wake_en),
      .flags_o(flags), .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
      .irq_rx_o(irq_rx), .irq_err_o(irq_err), .sck_oe_o(sck_oe)
   );

   initial begin
      tick_int = 1'b0;
      tick_ext = 1'b0;
      forever begin
         @(negedge clk);
         tick_int = int_run && !tick_int;
         tick_ext = ext_run && !tick_ext;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_frame(input logic [7:0] d, input logic mpb, input logic stop_bit);
      @(negedge clk);
      rx = 1'b0;
      repeat (BITCLK) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rx = d[i];
         repeat (BITCLK) @(negedge clk);
      end
      if (cfg_mp_en) begin
         rx = mpb;
         repeat (BITCLK) @(negedge clk);
      end
      rx = stop_bit;
      repeat (BITCLK) @(negedge clk);
      rx = 1'b1;
      repeat (3 * BITCLK) @(negedge clk);
   endtask

   task automatic pop_expect(input string req, input logic [7:0] exp);
      @(negedge clk);
      chk(req, rd_valid, 1'b1);
      chk(req, rd_data, exp);
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
   endtask

   task automatic clr_all();
      @(negedge clk);
      flag_clr = 4'hF;
      @(negedge clk);
      flag_clr = 4'h0;
   endtask

   task automatic write_arm(input logic v);
      @(negedge clk);
      wake_wr = 1'b1;
      wake_wdata = v;
      @(negedge clk);
      wake_wr = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R7 arm bit after reset", wake_en, 1'b0);
      chk("R9 flags after reset", flags, 4'h0);
      chk("R2 queue empty after reset", rd_valid, 1'b0);
      chk("R8 irqs after reset", {irq_rx, irq_err}, 2'b00);
   endtask

   task automatic t_normal();
      cfg_mp_en = 1'b0;
      send_frame(8'hA5, 1'b0, 1'b1);
      chk("R1 ready flag", flags, 4'h1);
      chk("R8 rx irq", {irq_rx, irq_err}, 2'b10);
      pop_expect("R1 plain frame", 8'hA5);
      chk("R2 queue drained", rd_valid, 1'b0);
      clr_all();
      chk("R9 clear", flags, 4'h0);
      cfg_mp_en = 1'b1;
      send_frame(8'h5A, 1'b0, 1'b1);
      chk("R1 mp data frame flags", flags, 4'h1);
      send_frame(8'hC3, 1'b1, 1'b1);
      chk("R9 mp bit flag unfiltered", flags, 4'h9);
      pop_expect("R1 mp frame 1", 8'h5A);
      pop_expect("R1 mp frame 2", 8'hC3);
      @(negedge clk);
      flag_clr = 4'h8;
      @(negedge clk);
      flag_clr = 4'h0;
      chk("R9 single flag clear", flags, 4'h1);
      clr_all();
   endtask

   task automatic t_suppress_and_wake();
      cfg_mp_en = 1'b1;
      write_arm(1'b1);
      chk("R7 software arm", wake_en, 1'b1);
      send_frame(8'h77, 1'b0, 1'b1);
      send_frame(8'h66, 1'b0, 1'b0);
      chk("R5 no queue write", rd_valid, 1'b0);
      chk("R5 no flags", flags, 4'h0);
      chk("R5 no irqs", {irq_rx, irq_err}, 2'b00);
      chk("R5 still armed", wake_en, 1'b1);
      send_frame(8'h3C, 1'b1, 1'b1);
      chk("R6 hardware disarm", wake_en, 1'b0);
      chk("R6 flags after id", flags, 4'h9);
      chk("R8 rx irq after wake", irq_rx, 1'b1);
      send_frame(8'h11, 1'b0, 1'b1);
      pop_expect("R6 id frame queued", 8'h3C);
      pop_expect("R6 data after wake", 8'h11);
      clr_all();
      write_arm(1'b1);
      send_frame(8'h42, 1'b1, 1'b0);
      chk("R6 id framing checked", flags, 4'hB);
      chk("R8 err irq", irq_err, 1'b1);
      pop_expect("R6 bad-stop id queued", 8'h42);
      clr_all();
   endtask

   task automatic t_ignored();
      write_arm(1'b1);
      cfg_mp_en = 1'b0;
      send_frame(8'h24, 1'b0, 1'b1);
      chk("R4 mp off arm ignored", flags, 4'h1);
      chk("R4 arm bit kept", wake_en, 1'b1);
      pop_expect("R4 mp off frame", 8'h24);
      clr_all();
      cfg_mp_en = 1'b1;
      cfg_irda = 1'b1;
      send_frame(8'h81, 1'b0, 1'b1);
      pop_expect("R4 irda arm ignored", 8'h81);
      cfg_irda = 1'b0;
      cfg_async = 1'b0;
      send_frame(8'h18, 1'b0, 1'b1);
      pop_expect("R4 sync arm ignored", 8'h18);
      cfg_async = 1'b1;
      write_arm(1'b0);
      chk("R7 software disarm", wake_en, 1'b0);
      clr_all();
   endtask

   task automatic t_fer();
      cfg_mp_en = 1'b0;
      cfg_rie = 1'b0;
      send_frame(8'h0F, 1'b0, 1'b0);
      chk("R3 framing flag", flags, 4'h3);
      chk("R8 irqs disabled", {irq_rx, irq_err}, 2'b00);
      cfg_rie = 1'b1;
      @(negedge clk);
      chk("R8 irqs enabled", {irq_rx, irq_err}, 2'b11);
      pop_expect("R3 bad frame queued", 8'h0F);
      clr_all();
   endtask

   task automatic t_overrun();
      cfg_mp_en = 1'b0;
      for (int i = 0; i < 17; i++) send_frame(8'(i * 7 + 1), 1'b0, 1'b1);
      chk("R2 overrun flag", flags, 4'h5);
      for (int i = 0; i < 16; i++) pop_expect("R2 order", 8'(i * 7 + 1));
      chk("R2 dropped frame absent", rd_valid, 1'b0);
      clr_all();
   endtask

   task automatic t_false_start();
      @(negedge clk);
      rx = 1'b0;
      repeat (8) @(negedge clk);
      rx = 1'b1;
      repeat (12 * BITCLK) @(negedge clk);
      chk("R12 false start no frame", rd_valid, 1'b0);
      chk("R12 false start no flags", flags, 4'h0);
      send_frame(8'h99, 1'b0, 1'b1);
      pop_expect("R12 recovers", 8'h99);
      clr_all();
   endtask

   task automatic t_clock();
      cfg_cke = 2'b01;
      @(negedge clk);
      chk("R11 clock pin driven", sck_oe, 1'b1);
      cfg_async = 1'b0;
      @(negedge clk);
      chk("R11 sync no drive", sck_oe, 1'b0);
      cfg_async = 1'b1;
      cfg_cke = 2'b11;
      @(negedge clk);
      chk("R11 external ignores cke0", sck_oe, 1'b0);
      int_run = 1'b0;
      ext_run = 1'b1;
      send_frame(8'hE7, 1'b0, 1'b1);
      pop_expect("R10 external tick", 8'hE7);
      cfg_cke = 2'b00;
      send_frame(8'h7E, 1'b0, 1'b1);
      chk("R10 internal tick stopped", rd_valid, 1'b0);
      int_run = 1'b1;
      ext_run = 1'b0;
      clr_all();
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4 * BITCLK) @(negedge clk);
      t_reset();
      t_normal();
      t_suppress_and_wake();
      t_ignored();
      t_fer();
      t_overrun();
      t_false_start();
      t_clock();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule